// File: doc/BRIEF.md
# ADC Mode and Calibration Sequencer

This block sits between a register write port and the conversion timer of a sigma-delta converter core. It holds the operating mode and a chop flag, a control byte, a filter word and an I/O configuration byte. It turns register writes into a restart strobe for the conversion timer. It steps the mode field back to idle when a single conversion or a calibration completes. It keeps a ready flag that says a fresh result is waiting.

While a calibration runs with chop enabled, the filter word handed to the conversion timer is forced to all ones. It returns to the programmed value when the calibration ends. With chop disabled, the programmed value is used throughout. Filter writes are dropped whenever the converter is busy.

Register addresses:

| Address | Register |
|---|---|
| 0 | mode |
| 1 | control |
| 2 | filter |
| 3 | I/O configuration |

In a mode write, bit 7 set means chop disabled, and bits 2:0 are the mode:

| Code | Mode |
|---|---|
| 000 | power-down |
| 001 | idle |
| 010 | single conversion |
| 011 | continuous conversion |
| 1xx | calibration |

Top module: `adc_mode_seq`

## Requirements
- R1: Every write to address 0 raises `restart` for exactly one cycle in the cycle after the write. This holds even when the written mode equals the current one.
- R2: A write to address 0 whose bits 2:0 are 1xx (calibration) clears `rdy` in the next cycle. The mode then stays at that calibration code until `conv_done`.
- R3: A `conv_done` pulse during calibration does three things in the next cycle: it returns `mode` to 001, it raises `cal_done` for one cycle, and it sets `rdy`.
- R4: With chop enabled (bit 7 of the last mode write is 0), `filt_eff` is 0xFF while `mode` is 1xx. After the calibration, `filt_eff` returns to the programmed filter value.
- R5: With chop disabled (bit 7 is 1), `filt_eff` equals `filt_user` during calibration.
- R6: A write to address 2 is ignored while `mode` is 010, 011 or 1xx. In power-down or idle it loads `filt_user` in the next cycle.
- R7: Writes to address 1 (control) and address 3 (I/O configuration) never raise `restart`. The I/O byte is stored with bits 7, 6, 3 and 2 forced to 0.
- R8: After reset:
  - `ctrl` is 0x07, `filt_user` is 0x45 and `io_cfg` is 0x00.
  - `mode` is 001 and `chop_off` is 0.
  - `rdy`, `restart` and `cal_done` are 0.
- R9: `conv_done` in single-conversion mode sets `rdy` and returns `mode` to 001. In continuous mode it sets `rdy` and leaves `mode` at 011. In power-down or idle it has no effect.
- R10: `rd_ack` clears `rdy` in the next cycle. When a `conv_done` that sets `rdy` arrives in the same cycle, `rdy` is set.
- R11: When a mode write and `conv_done` coincide, the write wins and the `conv_done` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DW | Register write data |
| conv_done | input | 1 | One-cycle pulse from the conversion timer at the end of a conversion period |
| rd_ack | input | 1 | Pulse marking that the result has been read |
| mode | output | 3 | Current mode field |
| chop_off | output | 1 | Chop disabled flag |
| ctrl | output | DW | Control byte |
| filt_user | output | DW | Programmed filter word |
| filt_eff | output | DW | Filter word used by the conversion timer |
| io_cfg | output | DW | I/O configuration byte |
| rdy | output | 1 | Result-ready status |
| restart | output | 1 | One-cycle restart strobe to the conversion timer |
| cal_done | output | 1 | One-cycle calibration-complete event |

## Verification
The bench writes the mode field with its current value to catch a design that restarts only on a change. It writes the filter during single, continuous and calibration modes, where a missing guard would show up as a changed `filt_user`. It runs calibrations with chop on and off, so that a design that forgets to force the filter, or forgets to restore it, shows a wrong `filt_eff`. It also lines up `conv_done` with `rd_ack` and with a mode write. A wrong priority there would leave `rdy` clear, or would drop the new mode back to idle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        MD_PWRDN  = 3'b000,
        MD_IDLE   = 3'b001,
        MD_SINGLE = 3'b010,
        MD_CONT   = 3'b011,
        MD_CAL_A  = 3'b100,
        MD_CAL_B  = 3'b101,
        MD_CAL_C  = 3'b110,
        MD_CAL_D  = 3'b111
    } mode_e;

    typedef struct packed {
        logic mode_wr;
        logic ctrl_wr;
        logic filt_wr;
        logic io_wr;
    } wr_sel_t;

    localparam int A_MODE = 0;
    localparam int A_CTRL = 1;
    localparam int A_FILT = 2;
    localparam int A_IO   = 3;

    localparam logic [7:0] CTRL_RST = 8'h07;
    localparam logic [7:0] FILT_RST = 8'h45;
    localparam logic [7:0] IO_RST   = 8'h00;
    localparam logic [7:0] IO_MASK  = 8'h33;

    function automatic logic is_cal(mode_e m);
        return m[2];
    endfunction

    function automatic logic is_busy(mode_e m);
        return m >= MD_SINGLE;
    endfunction

endpackage

// File: rtl/seq_wr_decode.sv
module seq_wr_decode
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_sel_t           sel
);
    always_comb begin
        sel         = '0;
        sel.mode_wr = wr_en && (wr_addr == ADDR_W'(A_MODE));
        sel.ctrl_wr = wr_en && (wr_addr == ADDR_W'(A_CTRL));
        sel.filt_wr = wr_en && (wr_addr == ADDR_W'(A_FILT));
        sel.io_wr   = wr_en && (wr_addr == ADDR_W'(A_IO));
    end
endmodule

// File: rtl/seq_mode_ctl.sv
module seq_mode_ctl
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_wr,
    input  logic [2:0] mode_bits,
    input  logic       chop_bit,
    input  logic       conv_done,
    input  logic       rd_ack,
    output mode_e      mode_q,
    output logic       chop_off_q,
    output logic       rdy_q,
    output logic       restart_q,
    output logic       cal_done_q
);
    logic  cd_eff;
    mode_e new_mode;

    assign new_mode = mode_e'(mode_bits);
    assign cd_eff   = conv_done && !mode_wr && is_busy(mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= MD_IDLE;
            chop_off_q <= 1'b0;
            rdy_q      <= 1'b0;
            restart_q  <= 1'b0;
            cal_done_q <= 1'b0;
        end else begin
            restart_q  <= mode_wr;
            cal_done_q <= cd_eff && is_cal(mode_q);
            if (mode_wr) begin
                mode_q     <= new_mode;
                chop_off_q <= chop_bit;
            end else if (cd_eff && mode_q != MD_CONT) begin
                mode_q <= MD_IDLE;
            end
            if (mode_wr && is_cal(new_mode))
                rdy_q <= 1'b0;
            else if (cd_eff)
                rdy_q <= 1'b1;
            else if (rd_ack)
                rdy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/seq_cfg_regs.sv
module seq_cfg_regs
    import adc_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_sel_t       sel,
    input  logic [DW-1:0] wr_data,
    input  mode_e         mode_q,
    input  logic          chop_off_q,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] filt_q,
    output logic [DW-1:0] filt_eff,
    output logic [DW-1:0] io_q
);
    localparam logic [DW-1:0] FILT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= DW'(CTRL_RST);
            filt_q <= DW'(FILT_RST);
            io_q   <= DW'(IO_RST);
        end else begin
            if (sel.ctrl_wr)
                ctrl_q <= wr_data;
            if (sel.filt_wr && !is_busy(mode_q))
                filt_q <= wr_data;
            if (sel.io_wr)
                io_q <= wr_data & DW'(IO_MASK);
        end
    end

    assign filt_eff = (is_cal(mode_q) && !chop_off_q) ? FILT_MAX : filt_q;
endmodule

// File: rtl/adc_mode_seq.sv
module adc_mode_seq
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              conv_done,
    input  logic              rd_ack,
    output logic [2:0]        mode,
    output logic              chop_off,
    output logic [DW-1:0]     ctrl,
    output logic [DW-1:0]     filt_user,
    output logic [DW-1:0]     filt_eff,
    output logic [DW-1:0]     io_cfg,
    output logic              rdy,
    output logic              restart,
    output logic              cal_done
);
    wr_sel_t sel;
    mode_e   mode_q;

    seq_wr_decode #(.ADDR_W(ADDR_W)) i_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .sel     (sel)
    );

    seq_mode_ctl i_mode (
        .clk        (clk),
        .rst        (rst),
        .mode_wr    (sel.mode_wr),
        .mode_bits  (wr_data[2:0]),
        .chop_bit   (wr_data[DW-1]),
        .conv_done  (conv_done),
        .rd_ack     (rd_ack),
        .mode_q     (mode_q),
        .chop_off_q (chop_off),
        .rdy_q      (rdy),
        .restart_q  (restart),
        .cal_done_q (cal_done)
    );

    seq_cfg_regs #(.DW(DW)) i_cfg (
        .clk        (clk),
        .rst        (rst),
        .sel        (sel),
        .wr_data    (wr_data),
        .mode_q     (mode_q),
        .chop_off_q (chop_off),
        .ctrl_q     (ctrl),
        .filt_q     (filt_user),
        .filt_eff   (filt_eff),
        .io_q       (io_cfg)
    );

    assign mode = mode_q;
endmodule

// File: rtl/adc_mode_seq_chk.sv
module adc_mode_seq_chk #(
    parameter int ADDR_W = 2,
    parameter int DW     = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic              conv_done,
    input logic [2:0]        mode,
    input logic [DW-1:0]     filt_user,
    input logic [DW-1:0]     filt_eff,
    input logic              rdy,
    input logic              restart,
    input logic              cal_done
);
    logic mwr, fwr, iwr;
    assign mwr = wr_en && wr_addr == ADDR_W'(0);
    assign fwr = wr_en && wr_addr == ADDR_W'(2);
    assign iwr = wr_en && (wr_addr == ADDR_W'(1) || wr_addr == ADDR_W'(3));

    p_restart_every_write_r1: assert property (@(posedge clk) disable iff (rst)
        mwr |=> restart);

    p_cal_clears_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (mwr && wr_data[2]) |=> !rdy);

    p_cal_ends_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (mode[2] && conv_done && !mwr) |=> (mode == 3'b001 && cal_done && rdy));

    p_chop_cal_forces_max_r4: assert property (@(posedge clk) disable iff (rst)
        (mwr && wr_data[2] && !wr_data[DW-1]) |=> filt_eff == {DW{1'b1}});

    p_nochop_cal_user_r5: assert property (@(posedge clk) disable iff (rst)
        (mwr && wr_data[2] && wr_data[DW-1]) |=> filt_eff == $past(filt_user));

    p_busy_filter_locked_r6: assert property (@(posedge clk) disable iff (rst)
        (fwr && mode >= 3'b010) |=> $stable(filt_user));

    p_cfg_write_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
        iwr |=> !restart);
endmodule

bind adc_mode_seq adc_mode_seq_chk #(.ADDR_W(ADDR_W), .DW(DW)) i_chk (.*);

// File: tb/test_adc_mode_seq.sv
`timescale 1ns/100ps
module test_adc_mode_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       conv_done = 1'b0;
    logic       rd_ack = 1'b0;
    logic [2:0] mode;
    logic       chop_off, rdy, restart, cal_done;
    logic [7:0] ctrl, filt_user, filt_eff, io_cfg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    adc_mode_seq i_adc_mode_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .conv_done(conv_done), .rd_ack(rd_ack), .mode(mode), .chop_off(chop_off),
        .ctrl(ctrl), .filt_user(filt_user), .filt_eff(filt_eff), .io_cfg(io_cfg),
        .rdy(rdy), .restart(restart), .cal_done(cal_done)
    );

    // behavioural reference
    int   m_mode;
    bit   m_chop_off, m_rdy, m_restart, m_cal_done;
    int   m_ctrl, m_filt, m_io, m_eff;
    int   old_mode;
    bit   cd_hit, is_mw;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 1; m_chop_off = 0; m_rdy = 0; m_restart = 0; m_cal_done = 0;
            m_ctrl = 'h07; m_filt = 'h45; m_io = 0;
        end else begin
            old_mode   = m_mode;
            is_mw      = wr_en && wr_addr == 0;
            cd_hit     = conv_done && !is_mw && old_mode >= 2;
            m_restart  = is_mw;
            m_cal_done = cd_hit && old_mode >= 4;
            if (is_mw) begin
                m_mode = wr_data[2:0];
                m_chop_off = wr_data[7];
            end else if (cd_hit && old_mode != 3) begin
                m_mode = 1;
            end
            if (is_mw && wr_data[2]) m_rdy = 0;
            else if (cd_hit)         m_rdy = 1;
            else if (rd_ack)         m_rdy = 0;
            if (wr_en && wr_addr == 1) m_ctrl = wr_data;
            if (wr_en && wr_addr == 2 && old_mode < 2) m_filt = wr_data;
            if (wr_en && wr_addr == 3) m_io = wr_data & 8'h33;
        end
        m_eff = (m_mode >= 4 && !m_chop_off) ? 'hFF : m_filt;
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk("R1",  "restart",   restart,   m_restart);
            chk("R3",  "mode",      mode,      m_mode);
            chk("R3",  "cal_done",  cal_done,  m_cal_done);
            chk("R10", "rdy",       rdy,       m_rdy);
            chk("R4",  "filt_eff",  filt_eff,  m_eff);
            chk("R6",  "filt_user", filt_user, m_filt);
            chk("R7",  "io_cfg",    io_cfg,    m_io);
            chk("R8",  "ctrl",      ctrl,      m_ctrl);
            chk("R5",  "chop_off",  chop_off,  m_chop_off);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1; wr_addr = a[1:0]; wr_data = d[7:0];
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pulse_done(input bit with_ack);
        @(negedge clk);
        conv_done = 1; rd_ack = with_ack;
        @(negedge clk);
        conv_done = 0; rd_ack = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R8 explicit reset values
        chk("R8", "reset ctrl", ctrl, 'h07);
        chk("R8", "reset filt", filt_user, 'h45);
        chk("R8", "reset io",   io_cfg, 0);
        chk("R8", "reset mode", mode, 1);

        // R7: config writes, no restart, io masked
        wr(1, 'h5A);
        wr(3, 'hFF);
        chk("R7", "io mask", io_cfg, 'h33);
        // R6: filter accepted in idle
        wr(2, 'h20);
        chk("R6", "filter idle", filt_user, 'h20);
        // R1: same-value mode write restarts
        @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = 'h01;
        @(negedge clk); wr_en = 0;
        chk("R1", "same value restart", restart, 1);

        // R9: single conversion
        wr(0, 'h02);
        wr(2, 'h10);                 // R6 ignored while busy
        chk("R6", "filter busy", filt_user, 'h20);
        idle(2);
        pulse_done(0);
        chk("R9", "single to idle", mode, 1);
        chk("R9", "single rdy", rdy, 1);
        @(negedge clk); rd_ack = 1; @(negedge clk); rd_ack = 0;
        chk("R10", "ack clears", rdy, 0);

        // R9 continuous, R10 tie, R11 tie
        wr(0, 'h03);
        pulse_done(0);
        chk("R9", "cont stays", mode, 3);
        pulse_done(1);
        chk("R10", "done beats ack", rdy, 1);
        @(negedge clk);
        wr_en = 1; wr_addr = 0; wr_data = 'h02; conv_done = 1;
        @(negedge clk);
        wr_en = 0; conv_done = 0;
        chk("R11", "write beats done", mode, 2);
        pulse_done(0);

        // R2/R3/R4: calibration, chop enabled
        wr(0, 'h04);
        chk("R2", "cal clears rdy", rdy, 0);
        chk("R4", "forced max", filt_eff, 'hFF);
        wr(2, 'h33);
        idle(3);
        pulse_done(0);
        chk("R3", "cal to idle", mode, 1);
        chk("R4", "restored", filt_eff, 'h20);

        // R5: calibration, chop disabled
        wr(0, 'h87);
        chk("R5", "user filter in cal", filt_eff, 'h20);
        pulse_done(0);
        chk("R3", "cal rdy", rdy, 1);

        // R9: conv_done ignored in idle and power-down
        pulse_done(0);
        chk("R9", "idle ignore", mode, 1);
        wr(0, 'h00);
        pulse_done(0);
        chk("R9", "pd ignore", mode, 0);
        wr(2, 'h0D);
        chk("R6", "filter pd", filt_user, 'h0D);
        wr(0, 'h06);
        pulse_done(1);
        idle(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule